// File: doc/BRIEF.md
# Charger Detection Timing Sequencer

This block steps through USB battery-charging detection when the chip powers up with a dead or weak battery. It runs on a free-running 32 kHz low-power clock, and every interval in the sequence is a whole number of cycles of that clock. Its inputs are comparator and receiver results that have already been synchronized to that clock. Its outputs turn the analog sources on the data lines on and off, report the kind of port that was found, and raise a done flag.

After a start strobe the sequencer waits for a debounced VBUS. It then checks the ID-resistance comparators for an accessory adapter. If none is present, it runs data contact detection with a current source on DP, followed by primary detection with the DP voltage source and the DM current sink. From the debounced results it settles on a standard port, a charging downstream port or a dedicated charger. Each comparator class has its own debounce counter, and that counter restarts whenever the input goes back before the count is complete.

Top module: `chg_det_seq`

## Requirements
- R1: After reset, idp_src_en_o, vdp_src_en_o, idm_sink_en_o, done_o and timeout_o are 0 and port_type_o is 00.
- R2: start_i is accepted only from idle or done. The sequence then waits until vbus_vld_i has been high for VBUS_DEB consecutive cycles. Two cycles later (one cycle of ID check) the DP current source turns on. In any state after that wait, a debounced loss of VBUS returns the block to idle one cycle after the debounce completes, with all enables and done low.
- R3: A debounced input follows its raw input only after that raw input has differed from the debounced value for the debounce count of consecutive cycles. A single-cycle return restarts the count.
- R4: Data contact is a debounced low on dp_se_i (SE_DEB cycles) while the DP current source is on. That debounce starts from a no-contact state at the beginning of contact detection. The current source stays on for at least IDP_MIN cycles. When DP is low from the start, the on-time is max(IDP_MIN, SE_DEB+1) cycles.
- R5: If no contact is seen, the DP current source turns off after DCD_TO cycles. timeout_o then rises and stays high until the next accepted start or a VBUS loss, and primary detection still follows.
- R6: vdp_src_en_o and idm_sink_en_o go high together in the cycle right after the DP current source turns off. They stay high for exactly PRIM cycles and are never high together with idp_src_en_o.
- R7: If vdm_cmp_i, debounced over VDM_DEB cycles, is low at the end of primary detection, done_o rises SESS cycles later with port_type_o = 01 (standard downstream port).
- R8: If the debounced vdm_cmp_i is high at the end of primary detection, done_o rises HICUR cycles later. port_type_o is then 11 (dedicated charger) when dm_se_i, debounced over SE_DEB cycles, is high, and 10 (charging downstream port) otherwise.
- R9: If any ID comparator (each debounced over ID_DEB cycles) is high at the ID check, no source is enabled. done_o rises ACA cycles later. The priority is RA first, then RB, then RC: RA gives 10, RB alone gives 11, and RC alone gives 10.
- R10: port_type_o is 00 whenever done_o is low. Once high, done_o and port_type_o hold until an accepted start or a VBUS loss.
- R11: A start_i pulse while the sequence is running has no effect on the enables or their timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32 kHz low-power clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe |
| vbus_vld_i | input | 1 | VBUS valid comparator |
| dp_se_i | input | 1 | DP single-ended receiver |
| dm_se_i | input | 1 | DM single-ended receiver |
| vdm_cmp_i | input | 1 | DM voltage-source comparator |
| id_ra_i | input | 1 | ID comparator, RA range |
| id_rb_i | input | 1 | ID comparator, RB range |
| id_rc_i | input | 1 | ID comparator, RC range |
| idp_src_en_o | output | 1 | DP current source enable |
| vdp_src_en_o | output | 1 | DP voltage source enable |
| idm_sink_en_o | output | 1 | DM current sink enable |
| port_type_o | output | 2 | 00 none, 01 standard, 10 charging downstream, 11 dedicated |
| done_o | output | 1 | Detection finished |
| timeout_o | output | 1 | Contact detection timed out |

## Verification
The bench builds the block with short intervals: VBUS_DEB 5, IDP_MIN 4, DCD_TO 40, PRIM 12, HICUR 9, SESS 20, VDM_DEB 3, SE_DEB 6, ID_DEB 6 and ACA 7. With these values every path through the sequence finishes in a few dozen cycles. This lets the bench sweep all eight combinations of DP contact, DM level and voltage comparator, and all seven nonzero ID patterns. It times each enable pulse and the done edge against closed-form expressions in these parameters. The same small counts also reach a contact glitch that restarts the debounce, and a VBUS loss in the middle of primary detection.

// File: rtl/chg_det_pkg.sv
package chg_det_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_WAIT, S_IDCHK, S_ACA, S_DCD, S_PRIM, S_SESS, S_HICUR, S_DONE
  } state_e;

  localparam logic [1:0] PT_NONE = 2'b00;
  localparam logic [1:0] PT_SDP  = 2'b01;
  localparam logic [1:0] PT_CDP  = 2'b10;
  localparam logic [1:0] PT_DCP  = 2'b11;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/chg_debounce.sv
module chg_debounce #(
  parameter int unsigned CYC  = 4,
  parameter logic        INIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic in_i,
  output logic q_o
);
  localparam int unsigned CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= INIT;
      cnt_q <= '0;
    end else if (clr_i) begin
      q_o   <= INIT;
      cnt_q <= '0;
    end else if (in_i != q_o) begin
      if (cnt_q == CW'(CYC - 1)) begin
        q_o   <= in_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;  // input came back: restart
    end
  end

  // R3
  deb_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(q_o) |-> ($past(clr_i) || (q_o == $past(in_i))));
endmodule

// File: rtl/chg_det_fsm.sv
module chg_det_fsm
  import chg_det_pkg::*;
#(
  parameter int unsigned IDP_MIN = 8,
  parameter int unsigned DCD_TO  = 89400,
  parameter int unsigned PRIM    = 1792,
  parameter int unsigned HICUR   = 1792,
  parameter int unsigned ACA     = 2300,
  parameter int unsigned SESS    = 53084160
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       vbus_ok_i,
  input  logic       dp_hi_i,
  input  logic       dm_hi_i,
  input  logic       vdm_ok_i,
  input  logic [2:0] id_hit_i,
  output logic       dp_clr_o,
  output logic       idp_src_en_o,
  output logic       vdp_src_en_o,
  output logic       idm_sink_en_o,
  output logic [1:0] port_type_o,
  output logic       done_o,
  output logic       timeout_o
);
  localparam int unsigned TMAX = max2(max2(max2(IDP_MIN, DCD_TO), max2(PRIM, HICUR)),
                                      max2(ACA, SESS));
  localparam int unsigned TW   = $clog2(TMAX + 1);

  state_e        state_q, state_d;
  logic [TW-1:0] tmr_q;
  logic [1:0]    type_q, type_d;
  logic          to_q, to_d;
  logic          timed;

  assign timed = (state_q == S_ACA) || (state_q == S_DCD) || (state_q == S_PRIM) ||
                 (state_q == S_SESS) || (state_q == S_HICUR);

  always_comb begin
    state_d = state_q;
    type_d  = type_q;
    to_d    = to_q;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d = S_WAIT;
        to_d    = 1'b0;
      end
      S_WAIT: if (vbus_ok_i) state_d = S_IDCHK;
      S_IDCHK: begin
        if (|id_hit_i) begin
          state_d = S_ACA;
          type_d  = id_hit_i[0] ? PT_CDP : (id_hit_i[1] ? PT_DCP : PT_CDP);
        end else begin
          state_d = S_DCD;
        end
      end
      S_ACA: if (tmr_q == TW'(ACA - 1)) state_d = S_DONE;
      S_DCD: begin
        if ((tmr_q >= TW'(IDP_MIN - 1)) && !dp_hi_i) begin
          state_d = S_PRIM;
        end else if (tmr_q == TW'(DCD_TO - 1)) begin
          state_d = S_PRIM;
          to_d    = 1'b1;
        end
      end
      S_PRIM: if (tmr_q == TW'(PRIM - 1)) state_d = vdm_ok_i ? S_HICUR : S_SESS;
      S_SESS: if (tmr_q == TW'(SESS - 1)) begin
        state_d = S_DONE;
        type_d  = PT_SDP;
      end
      S_HICUR: if (tmr_q == TW'(HICUR - 1)) begin
        state_d = S_DONE;
        type_d  = dm_hi_i ? PT_DCP : PT_CDP;
      end
      S_DONE: if (start_i) begin
        state_d = S_WAIT;
        to_d    = 1'b0;
      end
      default: state_d = S_IDLE;
    endcase
    // VBUS loss aborts any state past the initial wait
    if (state_q != S_IDLE && state_q != S_WAIT && !vbus_ok_i) begin
      state_d = S_IDLE;
      to_d    = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      tmr_q   <= '0;
      type_q  <= PT_NONE;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      type_q  <= type_d;
      to_q    <= to_d;
      if (state_d != state_q) tmr_q <= '0;
      else if (timed)         tmr_q <= tmr_q + 1'b1;
    end
  end

  assign dp_clr_o      = (state_q != S_DCD);
  assign idp_src_en_o  = (state_q == S_DCD);
  assign vdp_src_en_o  = (state_q == S_PRIM);
  assign idm_sink_en_o = (state_q == S_PRIM);
  assign done_o        = (state_q == S_DONE);
  assign port_type_o   = done_o ? type_q : PT_NONE;
  assign timeout_o     = to_q;

  // R2
  dcd_needs_vbus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idp_src_en_o) |-> $past(vbus_ok_i));
  // R6
  prim_after_dcd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vdp_src_en_o) |-> $past(idp_src_en_o));
  // R5
  timeout_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> ($past(state_q) == S_DCD));
  // R10
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> ($past(start_i) || !$past(vbus_ok_i)));
endmodule

// File: rtl/chg_det_seq.sv
module chg_det_seq #(
  parameter int unsigned VBUS_DEB = 459,
  parameter int unsigned IDP_MIN  = 8,
  parameter int unsigned DCD_TO   = 89400,
  parameter int unsigned PRIM     = 1792,
  parameter int unsigned HICUR    = 1792,
  parameter int unsigned VDM_DEB  = 760,
  parameter int unsigned SE_DEB   = 1520,
  parameter int unsigned ID_DEB   = 1520,
  parameter int unsigned ACA      = 2300,
  parameter int unsigned SESS     = 53084160
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       vbus_vld_i,
  input  logic       dp_se_i,
  input  logic       dm_se_i,
  input  logic       vdm_cmp_i,
  input  logic       id_ra_i,
  input  logic       id_rb_i,
  input  logic       id_rc_i,
  output logic       idp_src_en_o,
  output logic       vdp_src_en_o,
  output logic       idm_sink_en_o,
  output logic [1:0] port_type_o,
  output logic       done_o,
  output logic       timeout_o
);
  logic       vbus_ok, vdm_ok, dp_clr;
  logic [1:0] se_raw, se_clr, se_ok;
  logic [2:0] id_raw, id_ok;

  assign se_raw = {dm_se_i, dp_se_i};
  assign se_clr = {1'b0, dp_clr};
  assign id_raw = {id_rc_i, id_rb_i, id_ra_i};

  chg_debounce #(.CYC(VBUS_DEB), .INIT(1'b0)) u_vbus_deb (
    .clk_i, .rst_ni, .clr_i(1'b0), .in_i(vbus_vld_i), .q_o(vbus_ok));

  chg_debounce #(.CYC(VDM_DEB), .INIT(1'b0)) u_vdm_deb (
    .clk_i, .rst_ni, .clr_i(1'b0), .in_i(vdm_cmp_i), .q_o(vdm_ok));

  // index 0: DP starts from "no contact" (high); index 1: DM
  for (genvar g = 0; g < 2; g++) begin : g_se
    chg_debounce #(.CYC(SE_DEB), .INIT(g == 0)) u_deb (
      .clk_i, .rst_ni, .clr_i(se_clr[g]), .in_i(se_raw[g]), .q_o(se_ok[g]));
  end

  for (genvar g = 0; g < 3; g++) begin : g_id
    chg_debounce #(.CYC(ID_DEB), .INIT(1'b0)) u_deb (
      .clk_i, .rst_ni, .clr_i(1'b0), .in_i(id_raw[g]), .q_o(id_ok[g]));
  end

  chg_det_fsm #(
    .IDP_MIN(IDP_MIN), .DCD_TO(DCD_TO), .PRIM(PRIM),
    .HICUR(HICUR), .ACA(ACA), .SESS(SESS)
  ) u_fsm (
    .clk_i, .rst_ni, .start_i,
    .vbus_ok_i(vbus_ok), .dp_hi_i(se_ok[0]), .dm_hi_i(se_ok[1]),
    .vdm_ok_i(vdm_ok), .id_hit_i(id_ok), .dp_clr_o(dp_clr),
    .idp_src_en_o, .vdp_src_en_o, .idm_sink_en_o,
    .port_type_o, .done_o, .timeout_o
  );
endmodule

// File: tb/tb_chg_det_seq.sv
module tb_chg_det_seq;
  localparam int VB = 5, IMIN = 4, DTO = 40, PR = 12, HC = 9, SS = 20;
  localparam int VDB = 3, SED = 6, IDD = 6, AC = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, vbus = 0, dp = 0, dm = 0, vdm = 0, ra = 0, rb = 0, rc = 0;
  logic idp, vdp, idm, done, tmo;
  logic [1:0] pt;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  chg_det_seq #(
    .VBUS_DEB(VB), .IDP_MIN(IMIN), .DCD_TO(DTO), .PRIM(PR), .HICUR(HC),
    .VDM_DEB(VDB), .SE_DEB(SED), .ID_DEB(IDD), .ACA(AC), .SESS(SS)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vbus_vld_i(vbus),
    .dp_se_i(dp), .dm_se_i(dm), .vdm_cmp_i(vdm),
    .id_ra_i(ra), .id_rb_i(rb), .id_rc_i(rc),
    .idp_src_en_o(idp), .vdp_src_en_o(vdp), .idm_sink_en_o(idm),
    .port_type_o(pt), .done_o(done), .timeout_o(tmo)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic dpv, input logic dmv, input logic vdmv,
                     input logic [2:0] id, input int glitch);
    int t_first = -1, n_idp = 0, n_vdp = 0, n_idm = 0, t_vlast = -1, t_done = -1;
    bit overlap = 0, pt_bad = 0, sent = 0;
    int e_first, e_idp, e_done, e_type;
    bit contact;
    vbus = 0; start = 0;
    dp = dpv; dm = dmv; vdm = vdmv; {rc, rb, ra} = id;
    repeat (30) @(negedge clk);
    vbus = 1; start = 1;
    for (int k = 1; k < 400; k++) begin
      @(negedge clk);
      if (k == 1) start = 0;
      if (sent) begin start = 0; sent = 0; end
      if (idp && vdp) overlap = 1;
      if (!done && pt != 2'b00) pt_bad = 1;
      if (idp) begin
        if (t_first < 0) t_first = k;
        if (glitch >= 0 && n_idp == glitch) dp = 1;
        if (glitch >= 0 && n_idp == glitch + 1) dp = dpv;
        n_idp++;
      end
      if (vdp) begin
        if (n_vdp == 3) begin start = 1; sent = 1; end  // R11 stimulus
        n_vdp++; t_vlast = k;
      end
      if (idm) n_idm++;
      if (done) begin t_done = k; break; end
    end
    contact = (dpv == 1'b0) || (glitch >= 0);
    chk(!pt_bad, "R10 type while not done", 1, 0);
    chk(!overlap, "R6 exclusive sources", 1, 0);
    if (id != 3'b000) begin
      e_done = VB + 2 + AC;
      e_type = ra ? 2 : (rb ? 3 : 2);
      chk(n_idp + n_vdp + n_idm == 0, "R9 sources off", n_idp + n_vdp + n_idm, 0);
      chk(t_done == e_done, "R9 done time", t_done, e_done);
      chk(int'(pt) == e_type, "R9 type", pt, e_type);
    end else begin
      e_first = VB + 2;
      if (glitch >= 0) e_idp = glitch + SED + 2;
      else if (contact) e_idp = (IMIN > SED + 1) ? IMIN : SED + 1;
      else e_idp = DTO;
      chk(t_first == e_first, "R2 vbus debounce", t_first, e_first);
      chk(n_idp == e_idp, glitch >= 0 ? "R3 restart" : (contact ? "R4 dcd on" : "R5 dcd timeout"),
          n_idp, e_idp);
      chk(int'(tmo) == int'(!contact), "R5 timeout flag", tmo, !contact);
      chk(n_vdp == PR && n_idm == PR, "R6 prim width R11", n_vdp, PR);
      chk(t_vlast == t_first + n_idp + PR - 1, "R6 prim start", t_vlast, t_first + n_idp + PR - 1);
      e_done = t_vlast + 1 + (vdmv ? HC : SS);
      e_type = vdmv ? (dmv ? 3 : 2) : 1;
      chk(t_done == e_done, vdmv ? "R8 done time" : "R7 done time", t_done, e_done);
      chk(int'(pt) == e_type, vdmv ? "R8 type" : "R7 type", pt, e_type);
    end
    repeat (10) @(negedge clk);
    chk(done && int'(pt) == e_type, "R10 done hold", pt, e_type);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk({idp, vdp, idm, done, tmo, pt} == 7'b0, "R1 reset state", {idp, vdp, idm, done, tmo, pt}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({idp, vdp, idm, done, tmo, pt} == 7'b0, "R1 after release", {idp, vdp, idm, done, tmo, pt}, 0);
    for (int c = 0; c < 8; c++) run(c[0], c[1], c[2], 3'b000, -1);
    run(1'b0, 1'b0, 1'b1, 3'b000, 2);
    for (int i = 1; i < 8; i++) run(1'b0, 1'b0, 1'b0, i[2:0], -1);
    // R2 abort on VBUS loss mid primary
    vbus = 0; dp = 0; vdm = 0; {rc, rb, ra} = 3'b000;
    repeat (30) @(negedge clk);
    vbus = 1; start = 1;
    @(negedge clk); start = 0;
    for (int k = 0; k < 200 && !vdp; k++) @(negedge clk);
    repeat (2) @(negedge clk);
    vbus = 0;
    repeat (VB) @(negedge clk);
    chk(vdp == 1'b1, "R2 prim before abort", vdp, 1);
    @(negedge clk);
    chk({idp, vdp, idm, done} == 4'b0, "R2 abort outputs", {idp, vdp, idm, done}, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule